// File: doc/BRIEF.md
# EDID Segment and Offset Resender

This block sits between the source of I2C-over-AUX requests and the AUX request packer. It watches I2C writes that set the display-data segment pointer (address 0x30) and the display-data offset (address 0x50), and keeps its own copy of both. Some sinks lose their read pointer when a read arrives with the middle-of-transaction flag set. For these reads the block can replay the pointer state ahead of the read: it inserts a one-byte write of the segment, when that is non-zero, then a one-byte write of the offset. Only after that does it pass the read on.

Requests come in on a valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. The source must hold `req_valid` and all request fields steady until the request is accepted. Commands leave on a second valid/ready channel. Once `cmd_valid` is raised, the block keeps it and every command field stable until `cmd_ready` is seen high at a clock edge. The packer then reports the end of that transaction with a one-cycle `txn_done` pulse. Only one command is outstanding at a time. `deinit` is a plain control input that clears the tracked pointers.

The tracked offset advances by one 16-byte chunk after every qualifying read. Offsets that are a multiple of the 128-byte block need no replay. When a block ends, the segment copy returns to zero.

Top module: `edid_resender`

## Requirements
- R1: A non-native I2C write (`req_native`=0, `req_read`=0) with non-zero `req_len` to address SEG_ADDR (0x30) loads the segment copy from `req_data0`. A native write to that address leaves the copy unchanged.
- R2: A non-native I2C write with non-zero `req_len` to address EDID_ADDR (0x50) loads the offset copy from `req_data0`, zero-extended. A native write leaves it unchanged.
- R3: Only a non-native read with `req_mot`=1 and non-zero `req_len` qualifies for insertion and advances the tracking. Any other request is forwarded alone and leaves the segment and offset copies unchanged.
- R4: A qualifying read whose tracked offset has its low log2(BLOCK_BYTES) bits all zero (a multiple of 128) is forwarded with no inserted writes.
- R5: A qualifying read at any other offset is preceded by inserted commands. First comes a write of the segment to SEG_ADDR, but only if the segment is non-zero. Then comes a write of the offset's low byte to the read's own address. Each inserted command has `cmd_read`=0, `cmd_native`=0, `cmd_len`=1, `cmd_no_addr`=1, `cmd_no_stop`=1 and `cmd_inserted`=1. The payload byte is on `cmd_data0`.
- R6: After every qualifying read the offset copy grows by STEP_BYTES (16). When the new offset equals BLOCK_BYTES (0x80) or twice that (0x100), the segment copy becomes zero.
- R7: The original request is forwarded unchanged, with `cmd_inserted`=0 and `cmd_no_addr`=1. `cmd_no_stop` is 0 for a read and 1 for a write.
- R8: After a command handshake, `cmd_valid` stays low until a `txn_done` pulse arrives. `req_ready` returns high only after the `txn_done` for the forwarded command. A `txn_done` that arrives while no command is awaiting completion is ignored.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and the command fields do not change.
- R10: Reset, or a `deinit` pulse, sets both the segment and offset copies to zero. Reset also leaves `req_ready`=1 and `cmd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deinit | input | 1 | Clears the tracked segment and offset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_native | input | 1 | 1 = native AUX request, 0 = I2C-over-AUX |
| req_read | input | 1 | 1 = read, 0 = write |
| req_mot | input | 1 | Middle-of-transaction flag |
| req_addr | input | ADDR_W | Request address |
| req_len | input | LEN_W | Byte count |
| req_data0 | input | 8 | First payload byte (writes) |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Packer takes the command |
| cmd_native | output | 1 | Command is native |
| cmd_read | output | 1 | Command is a read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_len | output | LEN_W | Command byte count |
| cmd_data0 | output | 8 | First payload byte |
| cmd_no_addr | output | 1 | Suppress address-only framing |
| cmd_no_stop | output | 1 | Suppress stop after the transfer |
| cmd_inserted | output | 1 | Command was generated by the block |
| txn_done | input | 1 | Completion pulse for the issued command |

## Verification
The bench uses the default address and length widths (20 and 8), 128-byte blocks and 16-byte steps. It sets OFS_W to 12, so the offset can walk past 0x100. That reaches both segment-clearing points. It also reaches the case where only the low byte of an offset above 0xFF is replayed (0x110 goes out as 0x10). With 128-byte blocks, the aligned and unaligned paths and the clear at the end of a block all appear within a few reads of each other.

// File: rtl/edid_rs_pkg.sv
package edid_rs_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} seq_state_e;
  typedef enum logic [1:0] {PH_SEG = 2'd0, PH_OFS = 2'd1, PH_FWD = 2'd2} seq_phase_e;
endpackage

// File: rtl/edid_track.sv
module edid_track #(
  parameter int ADDR_W      = 20,
  parameter int LEN_W       = 8,
  parameter int OFS_W       = 16,
  parameter int BLOCK_BYTES = 128,
  parameter int STEP_BYTES  = 16,
  parameter int SEG_ADDR    = 'h30,
  parameter int EDID_ADDR   = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deinit,
  input  logic              accept,
  input  logic              req_native,
  input  logic              req_read,
  input  logic              req_mot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        req_data0,
  output logic [7:0]        seg_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic              qualify,
  output logic              need_seg,
  output logic              need_ofs
);
  localparam int BLK_LSB = $clog2(BLOCK_BYTES);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(STEP_BYTES);
  localparam logic [OFS_W-1:0] END1 = OFS_W'(BLOCK_BYTES);
  localparam logic [OFS_W-1:0] END2 = OFS_W'(2 * BLOCK_BYTES);

  logic i2c_wr, snoop_seg, snoop_ofs, aligned;
  logic [OFS_W-1:0] ofs_adv;

  assign i2c_wr    = !req_native && !req_read && (req_len != '0);
  assign snoop_seg = i2c_wr && (req_addr == ADDR_W'(SEG_ADDR));
  assign snoop_ofs = i2c_wr && (req_addr == ADDR_W'(EDID_ADDR));
  assign qualify   = !req_native && req_read && req_mot && (req_len != '0);
  assign aligned   = (ofs_q[BLK_LSB-1:0] == '0);
  assign need_ofs  = qualify && !aligned;
  assign need_seg  = need_ofs && (seg_q != 8'd0);
  assign ofs_adv   = ofs_q + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n || deinit) begin
      seg_q <= 8'd0;
      ofs_q <= '0;
    end else if (accept) begin
      if (snoop_seg) seg_q <= req_data0;
      if (snoop_ofs) ofs_q <= OFS_W'(req_data0);
      if (qualify) begin
        ofs_q <= ofs_adv;
        if (ofs_adv == END1 || ofs_adv == END2) seg_q <= 8'd0;
      end
    end
  end

  // R6: offset steps forward after a qualifying read
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    accept && qualify && !deinit |=> ofs_q == $past(ofs_q) + STEP);
  // R6: segment cleared at the end of the first block
  a_r6_seg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept && qualify && !deinit && (ofs_q + STEP == END1) |=> seg_q == 8'd0);
  // R10: deinit empties both copies
  a_r10_deinit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    deinit |=> seg_q == 8'd0 && ofs_q == '0);
  // R3: requests that neither snoop nor qualify leave tracking alone
  a_r3_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !deinit && !qualify && !snoop_seg && !snoop_ofs |=> $stable(seg_q) && $stable(ofs_q));
endmodule

// File: rtl/edid_seq.sv
module edid_seq
  import edid_rs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic              req_native,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        req_data0,
  input  logic              need_seg,
  input  logic              need_ofs,
  input  logic [7:0]        seg_now,
  input  logic [7:0]        ofs_now,
  input  logic              cmd_ready,
  input  logic              txn_done,
  output logic              cmd_valid,
  output seq_phase_e        phase,
  output logic              l_native,
  output logic              l_read,
  output logic [ADDR_W-1:0] l_addr,
  output logic [LEN_W-1:0]  l_len,
  output logic [7:0]        l_data0,
  output logic [7:0]        l_seg,
  output logic [7:0]        l_ofs
);
  seq_state_e state;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_valid = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_FWD;
      l_native <= 1'b0;
      l_read   <= 1'b0;
      l_addr   <= '0;
      l_len    <= '0;
      l_data0  <= 8'd0;
      l_seg    <= 8'd0;
      l_ofs    <= 8'd0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          l_native <= req_native;
          l_read   <= req_read;
          l_addr   <= req_addr;
          l_len    <= req_len;
          l_data0  <= req_data0;
          l_seg    <= seg_now;
          l_ofs    <= ofs_now;
          phase    <= need_seg ? PH_SEG : (need_ofs ? PH_OFS : PH_FWD);
          state    <= ST_ISSUE;
        end
        ST_ISSUE: if (cmd_ready) state <= ST_WAIT;
        ST_WAIT: if (txn_done) begin
          case (phase)
            PH_SEG:  begin phase <= PH_OFS; state <= ST_ISSUE; end
            PH_OFS:  begin phase <= PH_FWD; state <= ST_ISSUE; end
            default: state <= ST_IDLE;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: nothing new is offered before completion of the last command
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid && !req_ready);
  // R9: an offered command stays put under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(phase) && $stable(l_addr));
  // R8: the forwarded command's completion frees the request side
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WAIT && txn_done && phase == PH_FWD |=> req_ready);
endmodule

// File: rtl/edid_cmd_build.sv
module edid_cmd_build
  import edid_rs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int LEN_W    = 8,
  parameter int SEG_ADDR = 'h30
) (
  input  seq_phase_e        phase,
  input  logic              l_native,
  input  logic              l_read,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [LEN_W-1:0]  l_len,
  input  logic [7:0]        l_data0,
  input  logic [7:0]        l_seg,
  input  logic [7:0]        l_ofs,
  output logic              cmd_native,
  output logic              cmd_read,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [7:0]        cmd_data0,
  output logic              cmd_no_addr,
  output logic              cmd_no_stop,
  output logic              cmd_inserted
);
  always_comb begin
    cmd_native   = 1'b0;
    cmd_read     = 1'b0;
    cmd_len      = LEN_W'(1);
    cmd_no_addr  = 1'b1;
    cmd_no_stop  = 1'b1;
    cmd_inserted = 1'b1;
    cmd_addr     = l_addr;
    cmd_data0    = l_ofs;
    case (phase)
      PH_SEG: begin
        cmd_addr  = ADDR_W'(SEG_ADDR);
        cmd_data0 = l_seg;
      end
      PH_OFS: ;
      default: begin
        cmd_native   = l_native;
        cmd_read     = l_read;
        cmd_len      = l_len;
        cmd_data0    = l_data0;
        cmd_no_stop  = !l_read;
        cmd_inserted = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/edid_resender.sv
module edid_resender
  import edid_rs_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int LEN_W       = 8,
  parameter int OFS_W       = 16,
  parameter int BLOCK_BYTES = 128,
  parameter int STEP_BYTES  = 16,
  parameter int SEG_ADDR    = 'h30,
  parameter int EDID_ADDR   = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deinit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_native,
  input  logic              req_read,
  input  logic              req_mot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        req_data0,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_native,
  output logic              cmd_read,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [7:0]        cmd_data0,
  output logic              cmd_no_addr,
  output logic              cmd_no_stop,
  output logic              cmd_inserted,
  input  logic              txn_done
);
  logic accept, qualify, need_seg, need_ofs;
  logic [7:0] seg_q;
  logic [OFS_W-1:0] ofs_q;
  seq_phase_e phase;
  logic l_native, l_read;
  logic [ADDR_W-1:0] l_addr;
  logic [LEN_W-1:0] l_len;
  logic [7:0] l_data0, l_seg, l_ofs;

  edid_track #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .BLOCK_BYTES(BLOCK_BYTES),
    .STEP_BYTES(STEP_BYTES), .SEG_ADDR(SEG_ADDR), .EDID_ADDR(EDID_ADDR)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .deinit(deinit), .accept(accept),
    .req_native(req_native), .req_read(req_read), .req_mot(req_mot),
    .req_addr(req_addr), .req_len(req_len), .req_data0(req_data0),
    .seg_q(seg_q), .ofs_q(ofs_q), .qualify(qualify),
    .need_seg(need_seg), .need_ofs(need_ofs)
  );

  edid_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .req_native(req_native), .req_read(req_read),
    .req_addr(req_addr), .req_len(req_len), .req_data0(req_data0),
    .need_seg(need_seg), .need_ofs(need_ofs), .seg_now(seg_q), .ofs_now(ofs_q[7:0]),
    .cmd_ready(cmd_ready), .txn_done(txn_done), .cmd_valid(cmd_valid), .phase(phase),
    .l_native(l_native), .l_read(l_read), .l_addr(l_addr), .l_len(l_len),
    .l_data0(l_data0), .l_seg(l_seg), .l_ofs(l_ofs)
  );

  edid_cmd_build #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_ADDR(SEG_ADDR)) u_build (
    .phase(phase), .l_native(l_native), .l_read(l_read), .l_addr(l_addr),
    .l_len(l_len), .l_data0(l_data0), .l_seg(l_seg), .l_ofs(l_ofs),
    .cmd_native(cmd_native), .cmd_read(cmd_read), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_data0(cmd_data0), .cmd_no_addr(cmd_no_addr),
    .cmd_no_stop(cmd_no_stop), .cmd_inserted(cmd_inserted)
  );

  // R5: inserted commands are one-byte I2C writes with both options set
  a_r5_insert_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_inserted |-> !cmd_read && !cmd_native && cmd_len == LEN_W'(1)
                                  && cmd_no_addr && cmd_no_stop);
  // R7: a forwarded read keeps the stop
  a_r7_fwd_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_inserted && cmd_read |-> cmd_no_addr && !cmd_no_stop);
  // R4: an aligned qualifying read goes straight through
  a_r4_aligned_direct: assert property (@(posedge clk) disable iff (!rst_n)
    accept && qualify && !need_ofs |=> cmd_valid && !cmd_inserted);
endmodule

// File: tb/sim_edid_resender.sv
module sim_edid_resender;
  localparam int AW = 20;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic deinit = 1'b0;
  logic req_valid = 1'b0, req_native = 1'b0, req_read = 1'b0, req_mot = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0] req_data0 = 8'd0;
  logic cmd_ready = 1'b0, txn_done = 1'b0;
  logic req_ready, cmd_valid, cmd_native, cmd_read, cmd_no_addr, cmd_no_stop, cmd_inserted;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic [7:0] cmd_data0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  edid_resender #(.ADDR_W(AW), .LEN_W(LW), .OFS_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .deinit(deinit),
    .req_valid(req_valid), .req_ready(req_ready), .req_native(req_native),
    .req_read(req_read), .req_mot(req_mot), .req_addr(req_addr),
    .req_len(req_len), .req_data0(req_data0),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_native(cmd_native),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_data0(cmd_data0), .cmd_no_addr(cmd_no_addr), .cmd_no_stop(cmd_no_stop),
    .cmd_inserted(cmd_inserted), .txn_done(txn_done)
  );

  task automatic check(input string req, input bit ok, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic send(input logic nat, input logic rd, input logic mot,
                      input logic [AW-1:0] addr, input logic [LW-1:0] len, input logic [7:0] d0);
    @(negedge clk);
    req_native = nat; req_read = rd; req_mot = mot;
    req_addr = addr; req_len = len; req_data0 = d0;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Wait for a command, compare it, optionally stall, then complete it.
  task automatic take(input string req, input logic nat, input logic rd,
                      input logic [AW-1:0] addr, input logic [LW-1:0] len, input logic [7:0] d0,
                      input logic na, input logic ns, input logic ins, input int stall);
    logic [40:0] got, exp;
    int waited = 0;
    while (!cmd_valid && waited < 50) begin @(negedge clk); waited++; end
    exp = {nat, rd, addr, len, d0, na, ns, ins};
    got = {cmd_native, cmd_read, cmd_addr, cmd_len, cmd_data0, cmd_no_addr, cmd_no_stop, cmd_inserted};
    check(req, cmd_valid && got == exp, {22'd0, got}, {22'd0, exp});
    if (stall > 0) begin
      txn_done = 1'b1;               // stray completion while offered: ignored (R8)
      @(negedge clk);
      txn_done = 1'b0;
      repeat (stall) @(negedge clk);
      got = {cmd_native, cmd_read, cmd_addr, cmd_len, cmd_data0, cmd_no_addr, cmd_no_stop, cmd_inserted};
      check("R9 hold under back-pressure", cmd_valid && got == exp, {22'd0, got}, {22'd0, exp});
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    check("R8 idle after handshake", !cmd_valid && !req_ready, {62'd0, cmd_valid, req_ready}, 64'd0);
    repeat (2) @(negedge clk);
    check("R8 waits for done", !cmd_valid, {63'd0, cmd_valid}, 64'd0);
    txn_done = 1'b1;
    @(negedge clk);
    txn_done = 1'b0;
  endtask

  // shorthands
  task automatic i2c_wr(input logic [AW-1:0] addr, input logic [7:0] d0, input string req);
    send(1'b0, 1'b0, 1'b0, addr, 8'd1, d0);
    take(req, 1'b0, 1'b0, addr, 8'd1, d0, 1'b1, 1'b1, 1'b0, 0);
  endtask

  task automatic ins_seg(input logic [7:0] v, input string req);
    take(req, 1'b0, 1'b0, 20'h30, 8'd1, v, 1'b1, 1'b1, 1'b1, 0);
  endtask

  task automatic ins_ofs(input logic [7:0] v, input string req);
    take(req, 1'b0, 1'b0, 20'h50, 8'd1, v, 1'b1, 1'b1, 1'b1, 0);
  endtask

  task automatic qread_req;
    send(1'b0, 1'b1, 1'b1, 20'h50, 8'd16, 8'd0);
  endtask

  task automatic fwd_read(input string req);
    take(req, 1'b0, 1'b1, 20'h50, 8'd16, 8'd0, 1'b1, 1'b0, 1'b0, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset state", req_ready && !cmd_valid, {62'd0, req_ready, cmd_valid}, 64'd2);
  endtask

  task automatic t_native_pass;
    send(1'b1, 1'b0, 1'b0, 20'h50, 8'd1, 8'h40);
    take("R7 native write forwarded", 1'b1, 1'b0, 20'h50, 8'd1, 8'h40, 1'b1, 1'b1, 1'b0, 0);
    send(1'b1, 1'b1, 1'b0, 20'h100, 8'd4, 8'd0);
    take("R7 native read forwarded", 1'b1, 1'b1, 20'h100, 8'd4, 8'd0, 1'b1, 1'b0, 1'b0, 0);
    qread_req;  // offset still 0: native write ignored (R2), aligned (R4)
    fwd_read("R2 R4 native write not snooped, aligned read direct");
  endtask

  task automatic t_offset_snoop;
    i2c_wr(20'h50, 8'h20, "R7 i2c write forwarded");
    qread_req;
    ins_ofs(8'h20, "R2 R5 offset replay");
    fwd_read("R7 forwarded read after replay");
  endtask

  task automatic t_segment_block;
    i2c_wr(20'h30, 8'h01, "R1 segment write forwarded");
    i2c_wr(20'h50, 8'h70, "R2 offset write forwarded");
    qread_req;
    ins_seg(8'h01, "R1 R5 segment replay first");
    ins_ofs(8'h70, "R5 offset replay second");
    fwd_read("R5 read after both replays");
    qread_req;
    fwd_read("R4 offset 0x80 aligned, no replay");
    qread_req;
    ins_ofs(8'h90, "R6 segment cleared at 0x80, offset advanced");
    fwd_read("R6 read after offset replay");
  endtask

  task automatic t_nonqual;
    send(1'b0, 1'b1, 1'b0, 20'h50, 8'd16, 8'd0);
    take("R3 read without mot", 1'b0, 1'b1, 20'h50, 8'd16, 8'd0, 1'b1, 1'b0, 1'b0, 0);
    send(1'b0, 1'b1, 1'b1, 20'h50, 8'd0, 8'd0);
    take("R3 zero-length read", 1'b0, 1'b1, 20'h50, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 0);
    send(1'b1, 1'b1, 1'b1, 20'h50, 8'd16, 8'd0);
    take("R3 native read with mot", 1'b1, 1'b1, 20'h50, 8'd16, 8'd0, 1'b1, 1'b0, 1'b0, 0);
    send(1'b1, 1'b0, 1'b0, 20'h30, 8'd1, 8'h05);
    take("R1 native segment write forwarded", 1'b1, 1'b0, 20'h30, 8'd1, 8'h05, 1'b1, 1'b1, 1'b0, 0);
    qread_req;
    ins_ofs(8'hA0, "R3 R1 tracking unchanged, no segment replay");
    fwd_read("R3 read after replay");
  endtask

  task automatic t_boundary_256;
    i2c_wr(20'h30, 8'h02, "R1 segment 2");
    i2c_wr(20'h50, 8'hF0, "R2 offset 0xF0");
    qread_req;
    ins_seg(8'h02, "R5 segment 2 replay");
    ins_ofs(8'hF0, "R5 offset 0xF0 replay");
    fwd_read("R5 read at 0xF0");
    qread_req;
    fwd_read("R4 offset 0x100 aligned");
    qread_req;
    ins_ofs(8'h10, "R6 segment cleared at 0x100, low byte of 0x110");
    fwd_read("R6 read at 0x110");
  endtask

  task automatic t_backpressure;
    send(1'b0, 1'b0, 1'b0, 20'h50, 8'd1, 8'h44);
    take("R9 stalled forward write", 1'b0, 1'b0, 20'h50, 8'd1, 8'h44, 1'b1, 1'b1, 1'b0, 3);
    qread_req;
    take("R9 R8 stalled inserted write", 1'b0, 1'b0, 20'h50, 8'd1, 8'h44, 1'b1, 1'b1, 1'b1, 3);
    fwd_read("R8 read after stalled replay");
  endtask

  task automatic t_deinit;
    i2c_wr(20'h30, 8'h03, "R1 segment 3");
    i2c_wr(20'h50, 8'h30, "R2 offset 0x30");
    @(negedge clk);
    deinit = 1'b1;
    @(negedge clk);
    deinit = 1'b0;
    qread_req;
    fwd_read("R10 deinit cleared offset, aligned");
    qread_req;
    ins_ofs(8'h10, "R10 deinit cleared segment");
    fwd_read("R10 read after deinit");
  endtask

  initial begin
    t_reset;
    t_native_pass;
    t_offset_snoop;
    t_segment_block;
    t_nonqual;
    t_boundary_256;
    t_backpressure;
    t_deinit;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule